// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block generates the column address order for a single read or write burst in a double-data-rate SDRAM model or controller. A mode-register write programs two settings, the burst length (2, 4 or 8 beats) and the beat order (sequential or interleaved). A start strobe carries the first column of a burst. From the next cycle on, the block presents one column per cycle together with a valid flag. A last flag marks the final beat.

A burst never leaves the aligned block of columns whose size equals the burst length. The column bits above the block offset stay fixed for the whole burst. The offset bits inside the block advance by counting up with wrap-around in sequential order. In interleaved order they are the start offset XORed with the beat number. The programmed settings stay in force across any number of bursts until a valid write replaces them. Each burst keeps the settings that were in force at its start edge. A new start strobe cuts off a running burst.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, beat_vld and beat_last are low, and the settings are burst length 2 with sequential order.
- R2: A write with mrs_stb high and mrs_ba = 2'b00 sets the settings. The length code is mrs_addr[2:0]: 3'b001 gives 2 beats, 3'b010 gives 4 beats and 3'b011 gives 8 beats. mrs_addr[3] selects the order, 0 for sequential and 1 for interleaved. All higher mrs_addr bits have no effect. The new settings apply from the next edge.
- R3: A write with mrs_ba = 2'b00 that carries any other length code is reserved and is ignored as a whole, so both settings keep their values.
- R4: A write with mrs_ba other than 2'b00 leaves both settings unchanged. This includes the extended-register select 2'b01.
- R5: When start_stb is high at a rising edge, beat_vld is high in the following cycle and beat_col equals start_col. One further beat follows on each edge, so the burst has exactly the programmed number of beats.
- R6: In sequential order, the offset of beat i equals (start offset + i) modulo the burst length.
- R7: In interleaved order, the offset of beat i equals the start offset XOR i.
- R8: The offset is the low 1, 2 or 3 column bits for length 2, 4 or 8. Every column bit above the offset keeps the value of start_col for the whole burst, so the burst wraps inside its aligned block.
- R9: beat_last is high only on the final beat of a burst. After the final beat, beat_vld is low unless a new start was taken at that same edge.
- R10: A start_stb during a burst abandons the remaining beats. The new burst's first beat appears in the next cycle with no idle cycle.
- R11: Each burst uses the settings that were in force at its start edge. A mode write during a burst changes only later bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| mrs_stb | input | 1 | Mode-register write strobe |
| mrs_ba | input | 2 | Register select for the write (2'b00 selects the burst settings) |
| mrs_addr | input | ADDR_W | Write value; [2:0] holds the length code, [3] selects the order |
| start_stb | input | 1 | Starts a burst at this edge |
| start_col | input | COL_W | First column of the burst |
| beat_col | output | COL_W | Column of the current beat |
| beat_vld | output | 1 | A beat is present this cycle |
| beat_last | output | 1 | The current beat is the final one of its burst |

## Verification
A corrupted length register shows up within one burst: the last flag rises a beat too early or too late, and the column sequence goes past the block boundary or wraps inside a smaller block. A wrong order bit shows up on the second beat whenever the start offset is odd, because the sequential and interleaved successors differ there. A beat counter that lost its place shows up within one cycle, either as an extra valid beat after the last flag or as a column whose upper bits moved. The bench therefore compares every beat column and every last flag against its own expected list. It uses odd and mid-block start offsets, so that each of these faults changes a port value no later than the second beat.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int IDX_W = 3;  // offset bits for the longest burst (8 beats)

  typedef enum logic {ORDER_SEQ = 1'b0, ORDER_ILV = 1'b1} order_e;
  typedef logic [1:0] lg_t;  // log2 of the burst length: 1, 2 or 3

  // only three length codes are legal; the rest are reserved
  function automatic logic len_code_ok(input logic [2:0] code);
    return (code == 3'b001) || (code == 3'b010) || (code == 3'b011);
  endfunction

  // the legal codes map onto log2(length) through their low bits
  function automatic lg_t len_code_to_lg(input logic [2:0] code);
    return lg_t'(code[1:0]);
  endfunction

  // offset mask inside the aligned block for a given log2 length
  function automatic logic [IDX_W-1:0] lg_mask(input lg_t lg);
    logic [IDX_W-1:0] m;
    case (lg)
      2'd1:    m = 3'b001;
      2'd2:    m = 3'b011;
      2'd3:    m = 3'b111;
      default: m = 3'b001;
    endcase
    return m;
  endfunction

  // raw offset of a beat before masking; masking gives the modulo wrap
  function automatic logic [IDX_W-1:0] beat_offset(input logic [IDX_W-1:0] s,
                                                    input logic [IDX_W-1:0] i,
                                                    input order_e ord);
    return (ord == ORDER_ILV) ? (s ^ i) : (s + i);
  endfunction
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import bcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [1:0] wr_sel,
  input  logic [2:0] wr_len_code,
  input  logic       wr_order,
  output lg_t        len_lg,
  output order_e     order,
  output logic       wr_hit
);
  assign wr_hit = wr_stb && (wr_sel == 2'b00) && len_code_ok(wr_len_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_lg <= 2'd1;
      order  <= ORDER_SEQ;
    end else if (wr_hit) begin
      len_lg <= len_code_to_lg(wr_len_code);
      order  <= order_e'(wr_order);
    end
  end
endmodule

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_stb,
  input  logic [COL_W-1:0] start_col,
  input  lg_t              mode_lg,
  input  order_e           mode_ord,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic [COL_W-1:0] base,
  output lg_t              cur_lg,
  output order_e           cur_ord,
  output logic             final_beat
);
  assign final_beat = active && (idx == lg_mask(cur_lg));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      idx     <= '0;
      base    <= '0;
      cur_lg  <= 2'd1;
      cur_ord <= ORDER_SEQ;
    end else if (start_stb) begin
      active  <= 1'b1;
      idx     <= '0;
      base    <= start_col;
      cur_lg  <= mode_lg;
      cur_ord <= mode_ord;
    end else if (final_beat) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (active) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [IDX_W-1:0] idx,
  input  lg_t              lg,
  input  order_e           ord,
  output logic [COL_W-1:0] col
);
  logic [IDX_W-1:0] raw_off;
  logic [IDX_W-1:0] mask;

  assign raw_off = beat_offset(base[IDX_W-1:0], idx, ord);
  assign mask    = lg_mask(lg);

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    if (b < IDX_W) begin : g_low
      assign col[b] = mask[b] ? raw_off[b] : base[b];
    end else begin : g_high
      assign col[b] = base[b];
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrs_stb,
  input  logic [1:0]        mrs_ba,
  input  logic [ADDR_W-1:0] mrs_addr,
  input  logic              start_stb,
  input  logic [COL_W-1:0]  start_col,
  output logic [COL_W-1:0]  beat_col,
  output logic              beat_vld,
  output logic              beat_last
);
  // named internal events, visible to the bound checker
  lg_t              mode_lg;
  order_e           mode_ord;
  logic             mode_hit;
  logic             run_active;
  logic [IDX_W-1:0] run_idx;
  logic [COL_W-1:0] run_base;
  lg_t              run_lg;
  order_e           run_ord;
  logic             run_final;
  logic             unused_mrs_hi;

  assign unused_mrs_hi = ^mrs_addr[ADDR_W-1:4];

  bcs_mode_reg u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stb      (mrs_stb),
    .wr_sel      (mrs_ba),
    .wr_len_code (mrs_addr[2:0]),
    .wr_order    (mrs_addr[3]),
    .len_lg      (mode_lg),
    .order       (mode_ord),
    .wr_hit      (mode_hit)
  );

  bcs_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_stb  (start_stb),
    .start_col  (start_col),
    .mode_lg    (mode_lg),
    .mode_ord   (mode_ord),
    .active     (run_active),
    .idx        (run_idx),
    .base       (run_base),
    .cur_lg     (run_lg),
    .cur_ord    (run_ord),
    .final_beat (run_final)
  );

  bcs_col_gen #(.COL_W(COL_W)) u_col (
    .base (run_base),
    .idx  (run_idx),
    .lg   (run_lg),
    .ord  (run_ord),
    .col  (beat_col)
  );

  assign beat_vld  = run_active;
  assign beat_last = run_final;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
  import bcs_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mrs_stb,
  input logic [1:0]        mrs_ba,
  input logic [ADDR_W-1:0] mrs_addr,
  input logic              start_stb,
  input logic [COL_W-1:0]  start_col,
  input logic [COL_W-1:0]  beat_col,
  input logic              beat_vld,
  input logic              beat_last,
  input lg_t               mode_lg,
  input order_e            mode_ord
);
  p_first_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |=> beat_vld && (beat_col == $past(start_col)));

  p_upper_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && !beat_last && !start_stb) |=>
      beat_vld && (beat_col[COL_W-1:IDX_W] == $past(beat_col[COL_W-1:IDX_W])));

  p_last_with_vld_r9: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_vld);

  p_idle_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_last && !start_stb) |=> !beat_vld);

  p_other_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_stb && (mrs_ba != 2'b00)) |=> ($stable(mode_lg) && $stable(mode_ord)));

  p_reserved_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_stb && (mrs_ba == 2'b00) && !len_code_ok(mrs_addr[2:0])) |=>
      ($stable(mode_lg) && $stable(mode_ord)));

  p_len8_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_stb && (mrs_ba == 2'b00) && (mrs_addr[2:0] == 3'b011)) |=>
      (mode_lg == 2'd3) && (mode_ord == order_e'($past(mrs_addr[3]))));
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W), .ADDR_W(ADDR_W)) u_bcs_chk (.*);

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  localparam int COL_W  = 10;
  localparam int ADDR_W = 13;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mrs_stb = 1'b0;
  logic [1:0]        mrs_ba = '0;
  logic [ADDR_W-1:0] mrs_addr = '0;
  logic              start_stb = 1'b0;
  logic [COL_W-1:0]  start_col = '0;
  logic [COL_W-1:0]  beat_col;
  logic              beat_vld;
  logic              beat_last;

  always #4 clk = ~clk;  // 125 MHz

  burst_col_seq #(.COL_W(COL_W), .ADDR_W(ADDR_W)) i_burst_col_seq (.*);

  typedef struct packed {
    logic [COL_W-1:0] col;
    logic             last;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  // bench model of the settings
  int m_len = 2;
  bit m_ilv = 1'b0;

  task automatic report(input bit ok, input string tag, input string what);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (beat_vld) begin
        if (exp_q.size() == 0) begin
          report(1'b0, "R9", $sformatf("extra beat col=%h exp=none", beat_col));
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          report((beat_col == e.col) && (beat_last == e.last), t,
                 $sformatf("col=%h exp=%h last=%b exp=%b", beat_col, e.col, beat_last, e.last));
        end
      end else if (exp_q.size() != 0) begin
        report(1'b0, "R5", $sformatf("vld=0 exp=1 col exp=%h", exp_q[0].col));
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic mrs(input logic [1:0] ba, input logic [ADDR_W-1:0] a);
    @(negedge clk); #1;
    mrs_stb  = 1'b1;
    mrs_ba   = ba;
    mrs_addr = a;
    if (ba == 2'b00) begin
      case (a[2:0])
        3'b001: begin m_len = 2; m_ilv = a[3]; end
        3'b010: begin m_len = 4; m_ilv = a[3]; end
        3'b011: begin m_len = 8; m_ilv = a[3]; end
        default: ;
      endcase
    end
    @(posedge clk); #1;
    mrs_stb = 1'b0;
  endtask

  task automatic start_burst(input logic [COL_W-1:0] c, input string tag);
    int lo;
    int pos;
    int hi;
    @(negedge clk); #1;
    exp_q.delete();
    tag_q.delete();
    start_stb = 1'b1;
    start_col = c;
    lo  = int'(c) % m_len;
    hi  = int'(c) - lo;
    pos = lo;
    for (int i = 0; i < m_len; i++) begin
      exp_t e;
      if (m_ilv) e.col = COL_W'(hi + (lo ^ i));
      else       e.col = COL_W'(hi + pos);
      e.last = (i == m_len - 1);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      pos = (pos == m_len - 1) ? 0 : pos + 1;
    end
    @(posedge clk); #1;
    start_stb = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) begin
      @(negedge clk); #1;
    end
    repeat (2) @(negedge clk);
    #1;
  endtask

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    report(!beat_vld, "R1", $sformatf("vld=%b exp=0", beat_vld));
    report(!beat_last, "R1", $sformatf("last=%b exp=0", beat_last));

    // R1: default length 2, sequential; odd start wraps down
    start_burst(10'h035, "R1");
    drain();

    // R6: length 4 sequential, offset 2 -> 1E 1F 1C 1D
    mrs(2'b00, 13'h0002);
    start_burst(10'h01E, "R6");
    drain();

    // R8: length 8 sequential, offset 5, wraps inside the block of 8
    mrs(2'b00, 13'h0003);
    start_burst(10'h12D, "R8");
    drain();

    // R7: length 8 interleaved
    mrs(2'b00, 13'h000B);
    start_burst(10'h2AD, "R7");
    drain();

    // R7: length 4 interleaved, offset 3 -> 3 2 1 0
    mrs(2'b00, 13'h000A);
    start_burst(10'h003, "R7");
    drain();

    // R4: writes to other register selects leave length 4 interleaved
    mrs(2'b01, 13'h0003);
    mrs(2'b10, 13'h0001);
    mrs(2'b11, 13'h0003);
    start_burst(10'h0F5, "R4");
    drain();

    // R3: reserved length codes ignored, order bit too
    mrs(2'b00, 13'h0007);
    mrs(2'b00, 13'h0000);
    mrs(2'b00, 13'h0004);
    start_burst(10'h161, "R3");
    drain();

    // R2: length 2 sequential with upper address bits set
    mrs(2'b00, 13'h1FF1);
    start_burst(10'h3FF, "R2");
    drain();
    mrs(2'b00, 13'h1FF3);
    start_burst(10'h07A, "R2");
    drain();

    // R10: restart a length 8 burst in its fourth beat
    mrs(2'b00, 13'h0003);
    start_burst(10'h100, "R10");
    repeat (3) @(negedge clk);
    start_burst(10'h207, "R10");
    drain();

    // R10: back-to-back, new start on the last beat of a length 2 burst
    mrs(2'b00, 13'h0001);
    start_burst(10'h011, "R10");
    @(negedge clk);
    start_burst(10'h022, "R10");
    drain();

    // R11: mode write mid-burst does not disturb the running burst
    mrs(2'b00, 13'h000B);
    start_burst(10'h0C6, "R11");
    mrs(2'b00, 13'h0002);
    drain();
    start_burst(10'h0C6, "R11");
    drain();
    start_burst(10'h0C5, "R11");
    drain();

    // R9: idle after last beat
    report(!beat_vld && !beat_last, "R9",
           $sformatf("vld=%b last=%b exp=0 0", beat_vld, beat_last));
    report(exp_q.size() == 0, "R5", $sformatf("left=%0d exp=0", exp_q.size()));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule